// File: doc/BRIEF.md
# Rheostat Command Decoder and Control Register

This block sits behind the serial front end of a 1024-step digital rheostat. Each time the front end strobes in a 16-bit command word, the decoder interprets it and acts on the wiper register, a three-bit control register, the shutdown state and the storage sequencer. It enforces two safety gates: wiper writes and storage programming are both refused after reset until software opens them in the control register.

Read commands never return data in the same frame. The decoder places the requested value, zero-extended, in a response register, and the serial front end shifts it out during the next transfer. Slot reads are sent to the storage sequencer, and its reply loads the response register when it arrives. An active-low hardware restore input reloads the wiper from the storage sequencer's current value while it is held low.

Top module: `rheo_cmd_decoder`

## Requirements
- R1: After the system reset, wiperCode is 512 (midscale), shutdown is 0, respWord is 0, no request strobe is high, and all three control bits are 0.
- R2: Command word layout: bits 15:14 are padding, bits 13:10 are the opcode and bits 9:0 are the data. Opcode 1 loads the data into the wiper only while control bit 1 (wiper write allow) is 1. Otherwise the wiper is unchanged.
- R3: Opcode 7 copies data bits 1:0 into control bits 1:0. Control bit 2 (program success) cannot be written by it.
- R4: Opcode 3 pulses storeReq for one cycle, with storeData equal to the current wiper, only while control bit 0 (program enable) is 1. Otherwise no request is made.
- R5: A storeDone pulse sets control bit 2. An accepted store request clears it, and storeDone wins when both occur in the same cycle.
- R6: Opcode 4 loads restoreValue into the wiper, clears shutdown and pulses restoreReq, whatever the control bits hold.
- R7: While hwResetN is low, every cycle acts like R6 and every command is ignored. Control bits are untouched.
- R8: Opcode 2 loads respWord with the wiper value from before the frame, zero-extended.
- R9: Opcode 8 loads respWord with the three control bits, zero-extended (bit 0 enable, bit 1 write allow, bit 2 success).
- R10: Opcode 6 loads respWord with lastAddr, zero-extended.
- R11: Opcode 5 pulses memRdReq with memRdAddr equal to data bits 5:0. A later memRdValid loads respWord with memRdData, zero-extended, unless a read command loads respWord in that same cycle.
- R12: Opcode 9 sets shutdown to data bit 0. While shut down, commands are still executed.
- R13: Opcodes 0 and 10 to 15 change no output.
- R14: respWord holds its value across every frame that is not a read (opcodes 2, 6 and 8) and across cycles without memRdValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| hwResetN | input | 1 | Hardware restore request, active low, sampled each clock |
| cmdValid | input | 1 | Command word strobe |
| cmdWord | input | 16 | Command word from the serial front end |
| restoreValue | input | 10 | Wiper value that the storage sequencer restores |
| lastAddr | input | 6 | Address of the most recently programmed slot |
| memRdValid | input | 1 | Slot read data is valid |
| memRdData | input | 10 | Slot read data |
| storeDone | input | 1 | Programming completed successfully |
| wiperCode | output | 10 | Current wiper code |
| shutdown | output | 1 | Wiper disconnected |
| storeReq | output | 1 | Request to program storeData |
| storeData | output | 10 | Value to program |
| restoreReq | output | 1 | A restore took place |
| memRdReq | output | 1 | Slot read request |
| memRdAddr | output | 6 | Slot address for the read |
| respWord | output | 16 | Staged response for the next frame |

## Verification
The bench first attacks the gates. A design that ignored write allow would let the wiper move after reset. One that ignored program enable would raise storeReq early. One that let opcode 7 reach the success bit would report a success that never happened. It also checks restore during shutdown and a write-protected restore, so a decoder that gated restore on write allow, or left shutdown set, would fail. It holds hwResetN low while a wiper write is presented, which exposes a priority mistake. It confirms that the response lags by one frame and survives writes and unused opcodes, so a design that reloaded or cleared respWord on other frames, or returned unpadded data, would mismatch.

// File: rtl/rheo_pkg.sv
package rheo_pkg;
  parameter int CODE_W = 10;
  parameter int OP_W   = 4;
  parameter int SLOT_W = 6;
  parameter int WORD_W = 16;
  parameter int CTRL_W = 3;

  localparam int OP_LSB = CODE_W;
  localparam int OP_MSB = CODE_W + OP_W - 1;

  localparam int CB_PROG  = 0;
  localparam int CB_WRALW = 1;
  localparam int CB_OK    = 2;

  localparam logic [OP_W-1:0] OP_NOP      = 4'd0;
  localparam logic [OP_W-1:0] OP_WR_WIPER = 4'd1;
  localparam logic [OP_W-1:0] OP_RD_WIPER = 4'd2;
  localparam logic [OP_W-1:0] OP_STORE    = 4'd3;
  localparam logic [OP_W-1:0] OP_RESTORE  = 4'd4;
  localparam logic [OP_W-1:0] OP_RD_SLOT  = 4'd5;
  localparam logic [OP_W-1:0] OP_RD_LAST  = 4'd6;
  localparam logic [OP_W-1:0] OP_WR_CTRL  = 4'd7;
  localparam logic [OP_W-1:0] OP_RD_CTRL  = 4'd8;
  localparam logic [OP_W-1:0] OP_SHDN     = 4'd9;

  typedef struct packed {
    logic wrWiper;
    logic restore;
    logic store;
    logic rdWiper;
    logic rdSlot;
    logic rdLast;
    logic wrCtrl;
    logic rdCtrl;
    logic setShdn;
  } strobes_t;
endpackage

// File: rtl/rheo_cmd_ctrl.sv
module rheo_cmd_ctrl
  import rheo_pkg::*;
(
  input  logic              hwResetN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic              wrAllow,
  input  logic              progEn,
  output strobes_t          stb
);
  logic [OP_W-1:0] opField;
  logic            unusedPad;

  assign opField   = cmdWord[OP_MSB:OP_LSB];
  assign unusedPad = ^cmdWord[WORD_W-1:OP_MSB+1];

  // Hardware restore has priority; while it is low no command is decoded.
  always_comb begin
    stb = '0;
    if (!hwResetN) begin
      stb.restore = 1'b1;
    end else if (cmdValid) begin
      case (opField)
        OP_WR_WIPER: stb.wrWiper = wrAllow;
        OP_RD_WIPER: stb.rdWiper = 1'b1;
        OP_STORE:    stb.store   = progEn;
        OP_RESTORE:  stb.restore = 1'b1;
        OP_RD_SLOT:  stb.rdSlot  = 1'b1;
        OP_RD_LAST:  stb.rdLast  = 1'b1;
        OP_WR_CTRL:  stb.wrCtrl  = 1'b1;
        OP_RD_CTRL:  stb.rdCtrl  = 1'b1;
        OP_SHDN:     stb.setShdn = 1'b1;
        default:     stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/rheo_datapath.sv
module rheo_datapath
  import rheo_pkg::*;
#(
  parameter int RESET_CODE = 1 << (CODE_W - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [CODE_W-1:0] cmdData,
  input  logic [CODE_W-1:0] restoreValue,
  input  logic [SLOT_W-1:0] lastAddr,
  input  logic              memRdValid,
  input  logic [CODE_W-1:0] memRdData,
  input  logic              storeDone,
  output logic [CODE_W-1:0] wiperCode,
  output logic              shutdown,
  output logic              storeReq,
  output logic [CODE_W-1:0] storeData,
  output logic              restoreReq,
  output logic              memRdReq,
  output logic [SLOT_W-1:0] memRdAddr,
  output logic [WORD_W-1:0] respWord,
  output logic [CTRL_W-1:0] ctrlReg
);
  localparam logic [CODE_W-1:0] WIPER_INIT = CODE_W'(RESET_CODE);

  // Wiper and shutdown state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperCode <= WIPER_INIT;
      shutdown  <= 1'b0;
    end else begin
      if (stb.restore)      wiperCode <= restoreValue;
      else if (stb.wrWiper) wiperCode <= cmdData;
      if (stb.restore)      shutdown  <= 1'b0;
      else if (stb.setShdn) shutdown  <= cmdData[0];
    end
  end

  // Control register: two writable bits plus a status bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else begin
      if (stb.wrCtrl) begin
        ctrlReg[CB_PROG]  <= cmdData[CB_PROG];
        ctrlReg[CB_WRALW] <= cmdData[CB_WRALW];
      end
      if (storeDone)      ctrlReg[CB_OK] <= 1'b1;
      else if (stb.store) ctrlReg[CB_OK] <= 1'b0;
    end
  end

  // Requests to the storage sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeReq   <= 1'b0;
      storeData  <= '0;
      restoreReq <= 1'b0;
      memRdReq   <= 1'b0;
      memRdAddr  <= '0;
    end else begin
      storeReq   <= stb.store;
      restoreReq <= stb.restore;
      memRdReq   <= stb.rdSlot;
      if (stb.store)  storeData <= wiperCode;
      if (stb.rdSlot) memRdAddr <= cmdData[SLOT_W-1:0];
    end
  end

  // Staged response, zero-extended into the word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respWord <= '0;
    end else begin
      if (stb.rdWiper)     respWord <= WORD_W'(wiperCode);
      else if (stb.rdCtrl) respWord <= WORD_W'(ctrlReg);
      else if (stb.rdLast) respWord <= WORD_W'(lastAddr);
      else if (memRdValid) respWord <= WORD_W'(memRdData);
    end
  end
endmodule

// File: rtl/rheo_cmd_decoder.sv
module rheo_cmd_decoder
  import rheo_pkg::*;
#(
  parameter int RESET_CODE = 1 << (CODE_W - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwResetN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [CODE_W-1:0] restoreValue,
  input  logic [SLOT_W-1:0] lastAddr,
  input  logic              memRdValid,
  input  logic [CODE_W-1:0] memRdData,
  input  logic              storeDone,
  output logic [CODE_W-1:0] wiperCode,
  output logic              shutdown,
  output logic              storeReq,
  output logic [CODE_W-1:0] storeData,
  output logic              restoreReq,
  output logic              memRdReq,
  output logic [SLOT_W-1:0] memRdAddr,
  output logic [WORD_W-1:0] respWord
);
  strobes_t          stb;
  logic [CTRL_W-1:0] ctrlReg;

  rheo_cmd_ctrl ctrl_i (
    .hwResetN (hwResetN),
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .wrAllow  (ctrlReg[CB_WRALW]),
    .progEn   (ctrlReg[CB_PROG]),
    .stb      (stb)
  );

  rheo_datapath #(.RESET_CODE(RESET_CODE)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cmdData      (cmdWord[CODE_W-1:0]),
    .restoreValue (restoreValue),
    .lastAddr     (lastAddr),
    .memRdValid   (memRdValid),
    .memRdData    (memRdData),
    .storeDone    (storeDone),
    .wiperCode    (wiperCode),
    .shutdown     (shutdown),
    .storeReq     (storeReq),
    .storeData    (storeData),
    .restoreReq   (restoreReq),
    .memRdReq     (memRdReq),
    .memRdAddr    (memRdAddr),
    .respWord     (respWord),
    .ctrlReg      (ctrlReg)
  );
endmodule

// File: rtl/rheo_cmd_checker.sv
module rheo_cmd_checker
  import rheo_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hwResetN,
  input logic              cmdValid,
  input logic [WORD_W-1:0] cmdWord,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic              storeDone,
  input logic [CODE_W-1:0] restoreValue,
  input logic [CODE_W-1:0] wiperCode,
  input logic              shutdown,
  input logic              storeReq,
  input logic              restoreReq
);
  logic [OP_W-1:0] opField;
  assign opField = cmdWord[OP_MSB:OP_LSB];

  a_r2_wiper_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (hwResetN && cmdValid && opField == OP_WR_WIPER && !ctrlBits[CB_WRALW])
      |=> $stable(wiperCode));

  a_r4_store_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeReq) |-> $past(ctrlBits[CB_PROG] && cmdValid && hwResetN));

  a_r5_ok_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[CB_OK]) |-> $past(storeDone));

  a_r6_restore_load: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq |-> (wiperCode == $past(restoreValue)) && !shutdown);

  a_r7_hw_restore: assert property (@(posedge clk) disable iff (!rstN)
    !hwResetN |=> restoreReq);

  a_r12_shdn_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdown) |-> $past(hwResetN && cmdValid && opField == OP_SHDN && cmdWord[0]));
endmodule

bind rheo_cmd_decoder rheo_cmd_checker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .hwResetN     (hwResetN),
  .cmdValid     (cmdValid),
  .cmdWord      (cmdWord),
  .ctrlBits     (ctrlReg),
  .storeDone    (storeDone),
  .restoreValue (restoreValue),
  .wiperCode    (wiperCode),
  .shutdown     (shutdown),
  .storeReq     (storeReq),
  .restoreReq   (restoreReq)
);

// File: tb/rheo_cmd_decoder_tb.sv
module rheo_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hwResetN = 1'b1;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [9:0]  restoreValue = 10'h000;
  logic [5:0]  lastAddr = 6'h00;
  logic        memRdValid = 1'b0;
  logic [9:0]  memRdData = '0;
  logic        storeDone = 1'b0;
  logic [9:0]  wiperCode;
  logic        shutdown;
  logic        storeReq;
  logic [9:0]  storeData;
  logic        restoreReq;
  logic        memRdReq;
  logic [5:0]  memRdAddr;
  logic [15:0] respWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rheo_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .cmdValid(cmdValid),
    .cmdWord(cmdWord), .restoreValue(restoreValue), .lastAddr(lastAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .storeDone(storeDone),
    .wiperCode(wiperCode), .shutdown(shutdown), .storeReq(storeReq),
    .storeData(storeData), .restoreReq(restoreReq), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .respWord(respWord)
  );

  // Behavioural reference model
  int   mWiper, mCtl, mResp, mStData, mRdAddr;
  bit   mShdn, mSt, mRs, mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWiper = 512; mCtl = 0; mResp = 0; mStData = 0; mRdAddr = 0;
      mShdn = 0; mSt = 0; mRs = 0; mRd = 0;
    end else begin
      int op;
      int d;
      bit readCmd;
      bit clrOk;
      op = int'(cmdWord[13:10]);
      d = int'(cmdWord[9:0]);
      readCmd = 0; clrOk = 0;
      mSt = 0; mRs = 0; mRd = 0;
      if (!hwResetN) begin
        mWiper = int'(restoreValue); mShdn = 0; mRs = 1;
      end else if (cmdValid) begin
        if (op == 1 && (mCtl & 2) != 0) mWiper = d;
        if (op == 2) begin mResp = mWiper; readCmd = 1; end
        if (op == 3 && (mCtl & 1) != 0) begin mSt = 1; mStData = mWiper; clrOk = 1; end
        if (op == 4) begin mWiper = int'(restoreValue); mShdn = 0; mRs = 1; end
        if (op == 5) begin mRd = 1; mRdAddr = d % 64; end
        if (op == 6) begin mResp = int'(lastAddr); readCmd = 1; end
        if (op == 7) mCtl = (mCtl & 4) | (d % 4);
        if (op == 8) begin mResp = mCtl; readCmd = 1; end
        if (op == 9) mShdn = (d % 2) == 1;
      end
      if (memRdValid && !readCmd) mResp = int'(memRdData);
      if (storeDone) mCtl = mCtl | 4;
      else if (clrOk) mCtl = mCtl & 3;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 model wiperCode", int'(wiperCode), mWiper);
      chk("R12 model shutdown", int'(shutdown), int'(mShdn));
      chk("R4 model storeReq", int'(storeReq), int'(mSt));
      chk("R4 model storeData", int'(storeData), mStData);
      chk("R6 model restoreReq", int'(restoreReq), int'(mRs));
      chk("R11 model memRdReq", int'(memRdReq), int'(mRd));
      chk("R11 model memRdAddr", int'(memRdAddr), mRdAddr);
      chk("R14 model respWord", int'(respWord), mResp);
    end
  end

  task automatic sendCmd(input int op, input int d);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord = {2'b00, 4'(op), 10'(d)};
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); storeDone = 1'b1;
    @(negedge clk); storeDone = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wiper midscale", int'(wiperCode), 512);
    chk("R1 shutdown", int'(shutdown), 0);
    chk("R1 respWord", int'(respWord), 0);
    chk("R1 storeReq", int'(storeReq), 0);
    sendCmd(8, 0);
    chk("R1 control bits", int'(respWord), 0);

    // R2 locked write, R4 store without enable
    sendCmd(1, 10'h155);
    chk("R2 write while locked", int'(wiperCode), 512);
    sendCmd(3, 0);
    chk("R4 store disabled", int'(storeReq), 0);

    // R3 control writes
    sendCmd(7, 3);
    sendCmd(8, 0);
    chk("R9 read control", int'(respWord), 3);
    sendCmd(7, 10'h3FC);
    sendCmd(8, 0);
    chk("R3 only bits 1:0 written", int'(respWord), 0);
    sendCmd(7, 10'h3FF);
    sendCmd(8, 0);
    chk("R3 success bit not writable", int'(respWord), 3);

    // R2 open write, R8 read wiper
    sendCmd(1, 10'h155);
    chk("R2 write allowed", int'(wiperCode), 10'h155);
    sendCmd(2, 0);
    chk("R8 read wiper", int'(respWord), 10'h155);
    sendCmd(1, 10'h0AA);
    chk("R14 resp held after write", int'(respWord), 10'h155);

    // R4 store, R5 success bit
    sendCmd(3, 0);
    chk("R4 storeReq", int'(storeReq), 1);
    chk("R4 storeData", int'(storeData), 10'h0AA);
    @(negedge clk);
    chk("R4 single pulse", int'(storeReq), 0);
    pulseDone();
    sendCmd(8, 0);
    chk("R5 success set", int'(respWord), 7);
    sendCmd(3, 0);
    sendCmd(8, 0);
    chk("R5 success cleared by store", int'(respWord), 3);
    @(negedge clk);
    cmdValid = 1'b1; cmdWord = {2'b00, 4'd3, 10'd0}; storeDone = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; storeDone = 1'b0;
    sendCmd(8, 0);
    chk("R5 done wins over clear", int'(respWord), 7);

    // R12 shutdown, R6 restore
    restoreValue = 10'h2AA;
    sendCmd(9, 1);
    chk("R12 shutdown entered", int'(shutdown), 1);
    sendCmd(1, 10'h010);
    chk("R12 write during shutdown", int'(wiperCode), 10'h010);
    sendCmd(4, 0);
    chk("R6 restore wiper", int'(wiperCode), 10'h2AA);
    chk("R6 restore clears shutdown", int'(shutdown), 0);
    chk("R6 restoreReq", int'(restoreReq), 1);
    sendCmd(9, 1);
    sendCmd(9, 0);
    chk("R12 shutdown left", int'(shutdown), 0);
    sendCmd(7, 0);
    restoreValue = 10'h0F0;
    sendCmd(4, 0);
    chk("R6 restore while locked", int'(wiperCode), 10'h0F0);

    // R10 last address, R11 slot read
    lastAddr = 6'h21;
    sendCmd(6, 0);
    chk("R10 last address", int'(respWord), 6'h21);
    sendCmd(5, 10'h3C5);
    chk("R11 memRdReq", int'(memRdReq), 1);
    chk("R11 memRdAddr", int'(memRdAddr), 6'h05);
    chk("R11 resp not yet loaded", int'(respWord), 6'h21);
    @(negedge clk); memRdValid = 1'b1; memRdData = 10'h1A3;
    @(negedge clk); memRdValid = 1'b0;
    chk("R11 slot data staged", int'(respWord), 10'h1A3);

    // R13 unused opcodes
    sendCmd(7, 3);
    sendCmd(1, 10'h123);
    for (int op = 10; op < 16; op++) begin
      sendCmd(op, 10'h3FF);
      chk("R13 unused opcode wiper", int'(wiperCode), 10'h123);
      chk("R13 unused opcode shutdown", int'(shutdown), 0);
    end
    sendCmd(0, 10'h3FF);
    chk("R13 nop wiper", int'(wiperCode), 10'h123);
    chk("R14 resp after nops", int'(respWord), 10'h1A3);

    // R7 hardware restore overrides commands
    sendCmd(9, 1);
    restoreValue = 10'h333;
    @(negedge clk);
    hwResetN = 1'b0; cmdValid = 1'b1; cmdWord = {2'b00, 4'd1, 10'h011};
    @(negedge clk);
    @(negedge clk);
    chk("R7 hw restore wiper", int'(wiperCode), 10'h333);
    chk("R7 hw restore shutdown", int'(shutdown), 0);
    chk("R7 hw restoreReq", int'(restoreReq), 1);
    hwResetN = 1'b1; cmdValid = 1'b0;
    sendCmd(8, 0);
    chk("R7 control kept", int'(respWord), 7);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule